// File: doc/BRIEF.md
# Interrupt Distributor Register Bank

This block is the register file on the distribution side of a multi-core interrupt controller. For each interrupt it keeps a priority byte, a CPU-target mask and a two-bit trigger configuration. A simple byte-wide bus reaches all of this state. Each request carries an address, a write flag, write data and the index of the CPU that issues it. One cycle later the block returns registered read data and an error flag.

Internal interrupts (numbers below 32) keep one priority per CPU, and the CPU index of the request selects which copy is used. All CPUs share the priority of an interrupt at 32 or above. The behaviour of the target bytes depends on two parameters, the CPU count and a legacy-revision flag. When the block is built for a single CPU without that flag, the target bytes read as zero and drop writes. Interrupts 29 to 31 always report the requester's own CPU bit. Writes to internal targets are forced to fixed values. Pending tracking, arbitration and signalling sit in other blocks.

Top module: `irq_dist_regs`

## Requirements
- R1: Every request produces exactly one response, with `rspValid`, `rdData` and `rspErr` valid on the clock edge after the request is sampled. A write returns `rdData` = 0.
- R2: The priority bytes sit at offset 0x400 + (irq − BASE_IRQ). For irq below 32, each CPU reads and writes its own copy, selected by `reqCpu`.
- R3: For irq of 32 or more, all CPUs share one priority byte. A write from one CPU is visible to the others.
- R4: With one CPU and the legacy flag clear, every byte in 0x800–0xBFF reads as 0, never raises the error, and ignores writes.
- R5: A read of the target byte of irq 29, 30 or 31 returns the one-hot mask of the requesting CPU in the low NUM_CPU bits.
- R6: The target byte sits at offset 0x800 + (irq − BASE_IRQ). A write stores 0 for irq below 29, stores the all-CPU mask for irq 29 to 31, and otherwise stores the written value ANDed with the all-CPU mask.
- R7: A target access whose irq is NUM_IRQ or more raises `rspErr`, returns 0 and changes no state.
- R8: The configuration byte at offset 0xC00 + n covers irq 4n to 4n+3 (plus BASE_IRQ). Irq 4n+k uses bits [2k+1:2k]. Bits for irq at or above NUM_IRQ read as 0.
- R9: After reset, a single-CPU build routes every interrupt to CPU 0, so its targets read 0x01 when the target bytes are accessible.
- R10: After reset, all priorities and configuration bits are 0, and all targets in a multi-CPU build are 0.
- R11: An offset outside 0x400–0xEFF reads as 0, raises `rspErr` and ignores writes.
- R12: A priority or configuration access whose first irq is NUM_IRQ or more raises `rspErr`, returns 0 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 12 | Byte offset |
| reqWdata | input | 8 | Write data |
| reqCpu | input | CPU_IW | Index of the requesting CPU |
| rspValid | output | 1 | Response present |
| rdData | output | 8 | Read data (0 for writes and errors) |
| rspErr | output | 1 | Bad-register flag |

## Verification
Every result of this block is due on exactly one edge: the edge after the request is sampled. When the driver issues a request it records the cycle number at which the response is due. The monitor pops the next expected entry at each falling edge where `rspValid` is high, and compares the cycle as well as the data and the error flag. A response that arrives early, late, twice or not at all is therefore reported against R1. Stored-state effects are checked by later reads through the same bus. These include forced target values, banked priorities and writes that are ignored.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int ADDR_W = 12;
  localparam int IDX_W = 12;
  localparam int INTERNAL_IRQS = 32;
  localparam int PRIVATE_FIRST = 29;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_PRIO,
    SEL_TGT,
    SEL_CFG
  } rdSel_e;

  typedef struct packed {
    logic prioWr;
    logic tgtWr;
    logic cfgWr;
    rdSel_e rdSel;
    logic tgtRaz;
    logic err;
    logic [IDX_W-1:0] irq;
  } strobe_t;
endpackage

// File: rtl/irq_dist_ctrl.sv
module irq_dist_ctrl
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  parameter bit LEGACY_REV = 1'b0,
  parameter int BASE_IRQ = 0
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output strobe_t           strobes
);
  localparam int CW = IDX_W + 1;
  localparam bit TGT_RAZ = (NUM_CPU == 1) && !LEGACY_REV;
  localparam logic [CW-1:0] IRQ_LIMIT = CW'(NUM_IRQ);
  localparam logic [CW-1:0] BASE_OFS = CW'(BASE_IRQ);

  logic [CW-1:0] irqNum;
  logic wrOk;

  // Region decode from the top address bits
  always_comb begin
    strobes = '0;
    irqNum = '0;
    unique case (reqAddr[11:10])
      2'b01: begin
        strobes.rdSel = SEL_PRIO;
        irqNum = {3'b000, reqAddr[9:0]} + BASE_OFS;
        strobes.err = (irqNum >= IRQ_LIMIT);
      end
      2'b10: begin
        strobes.rdSel = SEL_TGT;
        if (TGT_RAZ) begin
          strobes.tgtRaz = 1'b1;
        end else begin
          irqNum = {3'b000, reqAddr[9:0]} + BASE_OFS;
          strobes.err = (irqNum >= IRQ_LIMIT);
        end
      end
      2'b11: begin
        if (reqAddr[9:8] != 2'b11) begin
          strobes.rdSel = SEL_CFG;
          irqNum = {1'b0, reqAddr[9:0], 2'b00} + BASE_OFS;
          strobes.err = (irqNum >= IRQ_LIMIT);
        end else begin
          strobes.err = 1'b1;
        end
      end
      default: strobes.err = 1'b1;
    endcase
    strobes.irq = irqNum[IDX_W-1:0];
    wrOk = reqValid && reqWrite && !strobes.err && !strobes.tgtRaz;
    strobes.prioWr = wrOk && (strobes.rdSel == SEL_PRIO);
    strobes.tgtWr = wrOk && (strobes.rdSel == SEL_TGT);
    strobes.cfgWr = wrOk && (strobes.rdSel == SEL_CFG);
  end
endmodule

// File: rtl/irq_dist_dpath.sv
module irq_dist_dpath
  import irq_dist_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  parameter int CPU_IW = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [7:0]        reqWdata,
  input  logic [CPU_IW-1:0] reqCpu,
  input  strobe_t           strobes,
  output logic              rspValid,
  output logic [7:0]        rdData,
  output logic              rspErr
);
  localparam int CW = IDX_W + 1;
  localparam int IRQ_IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int DEPTH = 1 << IRQ_IW;
  localparam int CPU_SLOTS = 1 << CPU_IW;
  localparam logic [CW-1:0] IRQ_LIMIT = CW'(NUM_IRQ);
  localparam logic [NUM_CPU-1:0] RESET_TGT = (NUM_CPU == 1) ? '1 : '0;

  logic [7:0] prioBank [CPU_SLOTS][INTERNAL_IRQS];
  logic [7:0] prioShared [DEPTH];
  logic [NUM_CPU-1:0] tgtMem [DEPTH];
  logic [1:0] cfgMem [DEPTH];

  logic [IRQ_IW-1:0] slot;
  logic [4:0] bankSlot;
  logic isInternal, isPrivate;
  logic [NUM_CPU-1:0] cpuMask, tgtWrVal;
  logic [CW-1:0] cfgNum [4];
  logic [3:0] cfgHit;
  logic [7:0] rdNext;
  logic privRd;

  assign slot = strobes.irq[IRQ_IW-1:0];
  assign bankSlot = strobes.irq[4:0];
  assign isInternal = strobes.irq < IDX_W'(INTERNAL_IRQS);
  assign isPrivate = isInternal && (strobes.irq >= IDX_W'(PRIVATE_FIRST));

  always_comb begin
    for (int c = 0; c < NUM_CPU; c++) cpuMask[c] = (reqCpu == CPU_IW'(c));
    for (int k = 0; k < 4; k++) begin
      cfgNum[k] = {1'b0, strobes.irq} + CW'(k);
      cfgHit[k] = cfgNum[k] < IRQ_LIMIT;
    end
    if (!isInternal) tgtWrVal = reqWdata[NUM_CPU-1:0];
    else if (isPrivate) tgtWrVal = '1;
    else tgtWrVal = '0;
  end

  // Read mux
  always_comb begin
    rdNext = '0;
    unique case (strobes.rdSel)
      SEL_PRIO: rdNext = isInternal ? prioBank[reqCpu][bankSlot] : prioShared[slot];
      SEL_TGT: begin
        if (!strobes.tgtRaz) begin
          rdNext[NUM_CPU-1:0] = isPrivate ? cpuMask : tgtMem[slot];
        end
      end
      SEL_CFG: begin
        for (int k = 0; k < 4; k++) begin
          rdNext[2*k +: 2] = cfgHit[k] ? cfgMem[cfgNum[k][IRQ_IW-1:0]] : 2'b00;
        end
      end
      default: rdNext = '0;
    endcase
    if (strobes.err || reqWrite) rdNext = '0;
  end

  // Storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < CPU_SLOTS; c++)
        for (int i = 0; i < INTERNAL_IRQS; i++) prioBank[c][i] <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        prioShared[i] <= '0;
        tgtMem[i] <= RESET_TGT;
        cfgMem[i] <= '0;
      end
    end else begin
      if (strobes.prioWr) begin
        if (isInternal) prioBank[reqCpu][bankSlot] <= reqWdata;
        else prioShared[slot] <= reqWdata;
      end
      if (strobes.tgtWr) tgtMem[slot] <= tgtWrVal;
      if (strobes.cfgWr) begin
        for (int k = 0; k < 4; k++) begin
          if (cfgHit[k]) cfgMem[cfgNum[k][IRQ_IW-1:0]] <= reqWdata[2*k +: 2];
        end
      end
    end
  end

  // Response register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr <= 1'b0;
      rdData <= '0;
      privRd <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspErr <= reqValid && strobes.err;
      rdData <= reqValid ? rdNext : '0;
      privRd <= reqValid && !reqWrite && (strobes.rdSel == SEL_TGT) &&
                !strobes.tgtRaz && !strobes.err && isPrivate;
    end
  end

  p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_no_spurious_rsp_r1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  p_err_reads_zero_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rdData == 8'h00));
  p_private_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    privRd |-> ($countones(rdData) == 1));
  p_no_wr_on_err_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.prioWr || strobes.tgtWr || strobes.cfgWr) |-> !strobes.err);
endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs #(
  parameter int NUM_IRQ = 64,
  parameter int NUM_CPU = 2,
  parameter bit LEGACY_REV = 1'b0,
  parameter int BASE_IRQ = 0,
  localparam int CPU_IW = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [11:0]       reqAddr,
  input  logic [7:0]        reqWdata,
  input  logic [CPU_IW-1:0] reqCpu,
  output logic              rspValid,
  output logic [7:0]        rdData,
  output logic              rspErr
);
  irq_dist_pkg::strobe_t strobes;

  irq_dist_ctrl #(
    .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .LEGACY_REV(LEGACY_REV), .BASE_IRQ(BASE_IRQ)
  ) u_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .strobes(strobes)
  );

  irq_dist_dpath #(
    .NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU), .CPU_IW(CPU_IW)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWdata(reqWdata), .reqCpu(reqCpu), .strobes(strobes),
    .rspValid(rspValid), .rdData(rdData), .rspErr(rspErr)
  );
endmodule

// File: tb/irq_dist_regs_tb.sv
module irq_dist_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [2:0] reqValid = '0;
  logic reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic reqCpu = 1'b0;
  logic [2:0] rspValid, rspErr;
  logic [7:0] rdData [3];

  int checks = 0;
  int errors = 0;
  int cycle = 0;
  always @(posedge clk) cycle <= cycle + 1;

  // 0: two CPUs, 1: one CPU, 2: one CPU with legacy flag
  irq_dist_regs #(.NUM_IRQ(64), .NUM_CPU(2), .LEGACY_REV(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid[0]), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqCpu(reqCpu), .rspValid(rspValid[0]), .rdData(rdData[0]),
    .rspErr(rspErr[0]));
  irq_dist_regs #(.NUM_IRQ(64), .NUM_CPU(1), .LEGACY_REV(1'b0)) u_dutUni (
    .clk(clk), .rstN(rstN), .reqValid(reqValid[1]), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqCpu(reqCpu), .rspValid(rspValid[1]), .rdData(rdData[1]),
    .rspErr(rspErr[1]));
  irq_dist_regs #(.NUM_IRQ(64), .NUM_CPU(1), .LEGACY_REV(1'b1)) u_dutLeg (
    .clk(clk), .rstN(rstN), .reqValid(reqValid[2]), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqCpu(reqCpu), .rspValid(rspValid[2]), .rdData(rdData[2]),
    .rspErr(rspErr[2]));

  logic [8:0] expQ [3][$];
  int dueQ [3][$];
  string tagQ [3][$];

  task automatic access(input int sel, input bit wr, input logic [11:0] a,
                        input logic [7:0] d, input bit cpu, input logic [7:0] expD,
                        input bit expE, input string tag);
    @(negedge clk);
    reqValid = '0;
    reqValid[sel] = 1'b1;
    reqWrite = wr;
    reqAddr = a;
    reqWdata = d;
    reqCpu = cpu;
    expQ[sel].push_back({expE, wr ? 8'h00 : expD});
    dueQ[sel].push_back(cycle + 1);
    tagQ[sel].push_back(tag);
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      for (int s = 0; s < 3; s++) begin
        if (rstN && rspValid[s]) begin
          checks++;
          if (expQ[s].size() == 0) begin
            errors++;
            $display("FAIL R1 dut%0d: unexpected response data=%h err=%b, expected none",
                     s, rdData[s], rspErr[s]);
          end else begin
            logic [8:0] e;
            int due;
            string t;
            e = expQ[s].pop_front();
            due = dueQ[s].pop_front();
            t = tagQ[s].pop_front();
            if ({rspErr[s], rdData[s]} !== e || cycle != due) begin
              errors++;
              $display("FAIL %s dut%0d: got data=%h err=%b cycle=%0d, expected data=%h err=%b cycle=%0d",
                       t, s, rdData[s], rspErr[s], cycle, e[7:0], e[8], due);
            end
          end
        end
      end
    end
  end

  bit done = 1'b0;
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rspValid !== 3'b000) begin
      errors++;
      $display("FAIL R1: reset rspValid=%b, expected 000", rspValid);
    end
    rstN = 1'b1;

    // R10 reset values, multi-CPU
    access(0, 0, 12'h400, 0, 0, 8'h00, 0, "R10");
    access(0, 0, 12'h430, 0, 1, 8'h00, 0, "R10");
    access(0, 0, 12'h828, 0, 0, 8'h00, 0, "R10");
    access(0, 0, 12'hC00, 0, 0, 8'h00, 0, "R10");
    // R2 banked priorities
    access(0, 1, 12'h405, 8'hA0, 0, 0, 0, "R2");
    access(0, 1, 12'h405, 8'h50, 1, 0, 0, "R2");
    access(0, 0, 12'h405, 0, 0, 8'hA0, 0, "R2");
    access(0, 0, 12'h405, 0, 1, 8'h50, 0, "R2");
    // R3 shared priority
    access(0, 1, 12'h428, 8'h77, 0, 0, 0, "R3");
    access(0, 0, 12'h428, 0, 1, 8'h77, 0, "R3");
    // R5 private targets
    access(0, 0, 12'h81D, 0, 0, 8'h01, 0, "R5");
    access(0, 0, 12'h81D, 0, 1, 8'h02, 0, "R5");
    access(0, 1, 12'h81F, 8'h00, 1, 0, 0, "R5");
    access(0, 0, 12'h81F, 0, 1, 8'h02, 0, "R5");
    // R6 forced and masked targets
    access(0, 1, 12'h805, 8'hFF, 0, 0, 0, "R6");
    access(0, 0, 12'h805, 0, 0, 8'h00, 0, "R6");
    access(0, 1, 12'h828, 8'hFE, 0, 0, 0, "R6");
    access(0, 0, 12'h828, 0, 1, 8'h02, 0, "R6");
    access(0, 1, 12'h82A, 8'h03, 1, 0, 0, "R6");
    access(0, 0, 12'h82A, 0, 0, 8'h03, 0, "R6");
    // R7 target out of range
    access(0, 0, 12'h840, 0, 0, 8'h00, 1, "R7");
    access(0, 1, 12'h840, 8'h01, 0, 0, 1, "R7");
    access(0, 0, 12'h83F, 0, 0, 8'h00, 0, "R7");
    // R12 priority/config out of range
    access(0, 0, 12'h440, 0, 0, 8'h00, 1, "R12");
    access(0, 1, 12'h440, 8'h11, 0, 0, 1, "R12");
    access(0, 0, 12'hC10, 0, 0, 8'h00, 1, "R12");
    access(0, 0, 12'h43F, 0, 0, 8'h00, 0, "R12");
    // R8 configuration packing
    access(0, 1, 12'hC01, 8'hE4, 0, 0, 0, "R8");
    access(0, 0, 12'hC01, 0, 1, 8'hE4, 0, "R8");
    access(0, 0, 12'hC00, 0, 0, 8'h00, 0, "R8");
    access(0, 1, 12'hC0F, 8'hFF, 0, 0, 0, "R8");
    access(0, 0, 12'hC0F, 0, 0, 8'hFF, 0, "R8");
    access(0, 0, 12'hC02, 0, 0, 8'h00, 0, "R8");
    // R11 undefined offsets
    access(0, 0, 12'h000, 0, 0, 8'h00, 1, "R11");
    access(0, 1, 12'h100, 8'h55, 0, 0, 1, "R11");
    access(0, 0, 12'h100, 0, 0, 8'h00, 1, "R11");
    access(0, 0, 12'hF00, 0, 0, 8'h00, 1, "R11");
    // R4 single CPU, target bytes hidden
    access(1, 0, 12'h828, 0, 0, 8'h00, 0, "R4");
    access(1, 1, 12'h828, 8'h01, 0, 0, 0, "R4");
    access(1, 0, 12'h828, 0, 0, 8'h00, 0, "R4");
    access(1, 0, 12'h81D, 0, 0, 8'h00, 0, "R4");
    access(1, 0, 12'h840, 0, 0, 8'h00, 0, "R4");
    access(1, 1, 12'h405, 8'h33, 0, 0, 0, "R2");
    access(1, 0, 12'h405, 0, 0, 8'h33, 0, "R2");
    // R9 single CPU legacy: reset targets routed to CPU 0
    access(2, 0, 12'h828, 0, 0, 8'h01, 0, "R9");
    access(2, 0, 12'h805, 0, 0, 8'h01, 0, "R9");
    access(2, 0, 12'h81D, 0, 0, 8'h01, 0, "R5");
    access(2, 1, 12'h828, 8'hFE, 0, 0, 0, "R6");
    access(2, 0, 12'h828, 0, 0, 8'h00, 0, "R6");
    // back-to-back alternation between instances
    access(0, 0, 12'h428, 0, 0, 8'h77, 0, "R1");
    access(2, 0, 12'h83F, 0, 0, 8'h01, 0, "R1");

    @(negedge clk);
    reqValid = '0;
    repeat (4) @(negedge clk);
    for (int s = 0; s < 3; s++) begin
      checks++;
      if (expQ[s].size() != 0) begin
        errors++;
        $display("FAIL R1 dut%0d: %0d responses missing, expected 0", s, expQ[s].size());
      end
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule